// File: doc/BRIEF.md
# Reset Cause Status Logic

This block keeps a record of why the processor was last reset and whether it was halted at that moment. It holds two flags: a time-out flag and a power-down flag. It presents them inside a status byte. For each reset it also chooses the class. A cold reset makes the neighbouring registers reload their defaults. A warm reset leaves them as they are. The program counter is sent back to address zero in both cases.

The events are sampled on the rising clock edge:

- a watchdog expiry strobe;
- an external reset strobe (already synchronous to the clock);
- a halted level;
- a halt-entry strobe;
- a flag-clear strobe, issued when software clears the watchdog.

Power-on reset is asynchronous and active high, and it overrides everything else. Each output pulse appears in the cycle after the edge that sampled its event. The processor core, the watchdog counter and the oscillator lie outside this block.

Top module: `rst_cause_status`

## Requirements
- R1: While `por` is high, `flag_to` and `flag_pd` are 0, `pc_reset` and `cold_reset` are 1, and `warm_reset` is 0.
- R2: A watchdog expiry sampled while not halted sets `flag_to` to 1, keeps `flag_pd`, and pulses `pc_reset` and `cold_reset` in the next cycle.
- R3: An external reset sampled while not halted leaves both flags unchanged, and pulses `pc_reset` and `cold_reset` in the next cycle.
- R4: An external reset sampled while halted gives `flag_to`=0 and `flag_pd`=1, with `pc_reset` and `cold_reset` pulsed.
- R5: A watchdog expiry sampled while halted gives `flag_to`=1 and `flag_pd`=1. It is a warm reset: `warm_reset` and `pc_reset` pulse for one cycle and `cold_reset` stays 0.
- R6: Every reset event drives `pc_reset` high in the following cycle. A cycle with no reset event drives it low in the following cycle.
- R7: An external reset outranks a coincident watchdog expiry. Power-on reset outranks every other input.
- R8: A halt-entry strobe with no reset event gives `flag_to`=0 and `flag_pd`=1. A flag-clear strobe alone gives both flags 0. Halt entry wins over flag clear when both arrive in the same cycle.
- R9: In `status_o`, bit 5 is the time-out flag and bit 4 is the power-down flag. All other bits read 0.
- R10: `warm_reset` and `cold_reset` are never high together. Each one falls in the cycle after its event unless a new event of the same class arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, asynchronous, active high |
| wdt_expire | input | 1 | Watchdog expiry strobe |
| ext_rst | input | 1 | External reset strobe, synchronous |
| halted | input | 1 | Processor is in the halt state |
| halt_enter | input | 1 | Strobe: processor enters halt |
| flag_clear | input | 1 | Strobe: watchdog cleared by software |
| flag_to | output | 1 | Time-out flag |
| flag_pd | output | 1 | Power-down flag |
| status_o | output | STATUS_W | Status byte with the flags in place |
| pc_reset | output | 1 | Program counter to address zero |
| cold_reset | output | 1 | Other registers reload their defaults |
| warm_reset | output | 1 | Warm reset, other registers keep their values |

## Verification
The bench builds the block with its default parameters: an 8-bit status byte, the time-out flag at bit 5 and the power-down flag at bit 4. With these values the whole status byte can be compared against the required layout. Directed steps cover each reset source in both halt states, the ties between coincident sources, and power-on reset raised asynchronously in the middle of a run. A long seeded random run then mixes all five event inputs, with coincident strobes made frequent. This brings back-to-back warm resets and resets arriving on top of halt entry or flag clear within reach.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_CLEAR,
    EV_HALT,
    EV_WDT_RUN,
    EV_WDT_HALT,
    EV_EXT_RUN,
    EV_EXT_HALT
  } rcs_event_e;

  typedef struct packed {
    logic to;
    logic pd;
  } rcs_flags_t;

  // Priority: external reset, watchdog, halt entry, flag clear
  function automatic rcs_event_e rcs_pick(input logic wdt, input logic ext,
                                          input logic hlt, input logic hent,
                                          input logic clr);
    rcs_event_e ev;
    ev = EV_NONE;
    if (ext)       ev = hlt ? EV_EXT_HALT : EV_EXT_RUN;
    else if (wdt)  ev = hlt ? EV_WDT_HALT : EV_WDT_RUN;
    else if (hent) ev = EV_HALT;
    else if (clr)  ev = EV_CLEAR;
    return ev;
  endfunction

  function automatic rcs_flags_t rcs_next(input rcs_event_e ev,
                                          input rcs_flags_t cur);
    rcs_flags_t nx;
    nx = cur;
    case (ev)
      EV_CLEAR:    nx = '{to: 1'b0, pd: 1'b0};
      EV_HALT:     nx = '{to: 1'b0, pd: 1'b1};
      EV_WDT_RUN:  nx.to = 1'b1;
      EV_WDT_HALT: nx = '{to: 1'b1, pd: 1'b1};
      EV_EXT_HALT: nx = '{to: 1'b0, pd: 1'b1};
      default:     nx = cur;
    endcase
    return nx;
  endfunction

  function automatic logic rcs_is_reset(input rcs_event_e ev);
    return (ev == EV_WDT_RUN) || (ev == EV_WDT_HALT) ||
           (ev == EV_EXT_RUN) || (ev == EV_EXT_HALT);
  endfunction

  function automatic logic rcs_is_warm(input rcs_event_e ev);
    return ev == EV_WDT_HALT;
  endfunction

endpackage

// File: rtl/rcs_event_arb.sv
module rcs_event_arb
  import rcs_pkg::*;
(
  input  logic       wdt_expire,
  input  logic       ext_rst,
  input  logic       halted,
  input  logic       halt_enter,
  input  logic       flag_clear,
  output rcs_event_e ev,
  output logic       ev_reset,
  output logic       ev_warm
);

  always_comb begin
    ev       = rcs_pick(wdt_expire, ext_rst, halted, halt_enter, flag_clear);
    ev_reset = rcs_is_reset(ev);
    ev_warm  = rcs_is_warm(ev);
  end

  // R7: a coincident external reset always yields an external-reset class
  always_comb begin
    if (ext_rst) begin
      p_ext_wins_r7: assert (ev == EV_EXT_RUN || ev == EV_EXT_HALT);
    end
  end

endmodule

// File: rtl/rcs_flag_reg.sv
module rcs_flag_reg
  import rcs_pkg::*;
(
  input  logic       clk,
  input  logic       por,
  input  rcs_event_e ev,
  output rcs_flags_t flags_q
);

  rcs_flags_t flags_d;

  always_comb flags_d = rcs_next(ev, flags_q);

  always_ff @(posedge clk or posedge por) begin
    if (por) flags_q <= '{to: 1'b0, pd: 1'b0};
    else     flags_q <= flags_d;
  end

  // R8: after a clear event both flags are low
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (por)
    (ev == EV_CLEAR) |=> (flags_q.to == 1'b0 && flags_q.pd == 1'b0));

endmodule

// File: rtl/rcs_strobe_gen.sv
module rcs_strobe_gen (
  input  logic clk,
  input  logic por,
  input  logic ev_reset,
  input  logic ev_warm,
  output logic pc_reset,
  output logic cold_reset,
  output logic warm_reset
);

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      pc_reset   <= 1'b1;
      cold_reset <= 1'b1;
      warm_reset <= 1'b0;
    end else begin
      pc_reset   <= ev_reset;
      cold_reset <= ev_reset & ~ev_warm;
      warm_reset <= ev_warm;
    end
  end

  // R10: the two reset classes exclude each other
  p_class_excl_r10: assert property (@(posedge clk) disable iff (por)
    !(warm_reset && cold_reset));

  // R6: every class pulse comes with a program counter pulse
  p_pc_with_class_r6: assert property (@(posedge clk) disable iff (por)
    (warm_reset || cold_reset) |-> pc_reset);

endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
  import rcs_pkg::*;
#(
  parameter int STATUS_W = 8,
  parameter int TO_BIT   = 5,
  parameter int PD_BIT   = 4
) (
  input  logic                clk,
  input  logic                por,
  input  logic                wdt_expire,
  input  logic                ext_rst,
  input  logic                halted,
  input  logic                halt_enter,
  input  logic                flag_clear,
  output logic                flag_to,
  output logic                flag_pd,
  output logic [STATUS_W-1:0] status_o,
  output logic                pc_reset,
  output logic                cold_reset,
  output logic                warm_reset
);

  localparam int LAST_BIT = STATUS_W - 1;

  rcs_event_e ev;
  logic       ev_reset;
  logic       ev_warm;
  rcs_flags_t flags_q;

  rcs_event_arb u_arb (
    .wdt_expire (wdt_expire),
    .ext_rst    (ext_rst),
    .halted     (halted),
    .halt_enter (halt_enter),
    .flag_clear (flag_clear),
    .ev         (ev),
    .ev_reset   (ev_reset),
    .ev_warm    (ev_warm)
  );

  rcs_flag_reg u_flags (
    .clk     (clk),
    .por     (por),
    .ev      (ev),
    .flags_q (flags_q)
  );

  rcs_strobe_gen u_strobe (
    .clk        (clk),
    .por        (por),
    .ev_reset   (ev_reset),
    .ev_warm    (ev_warm),
    .pc_reset   (pc_reset),
    .cold_reset (cold_reset),
    .warm_reset (warm_reset)
  );

  assign flag_to = flags_q.to;
  assign flag_pd = flags_q.pd;

  for (genvar b = 0; b <= LAST_BIT; b++) begin : g_status
    if (b == TO_BIT) begin : g_to
      assign status_o[b] = flags_q.to;
    end else if (b == PD_BIT) begin : g_pd
      assign status_o[b] = flags_q.pd;
    end else begin : g_zero
      assign status_o[b] = 1'b0;
    end
  end

  // R2: watchdog expiry in normal run sets time-out, keeps power-down
  p_wdt_run_r2: assert property (@(posedge clk) disable iff (por)
    (wdt_expire && !ext_rst && !halted) |=> (flag_to && $stable(flag_pd) && cold_reset));

  // R3: external reset in normal run keeps both flags
  p_ext_run_r3: assert property (@(posedge clk) disable iff (por)
    (ext_rst && !halted) |=> ($stable(flag_to) && $stable(flag_pd)));

  // R4: external reset while halted
  p_ext_halt_r4: assert property (@(posedge clk) disable iff (por)
    (ext_rst && halted) |=> (!flag_to && flag_pd && cold_reset));

  // R5: watchdog while halted is a warm reset
  p_wdt_halt_r5: assert property (@(posedge clk) disable iff (por)
    (wdt_expire && halted && !ext_rst) |=> (flag_to && flag_pd && warm_reset && !cold_reset));

  // R6: any reset event gives a program counter pulse
  p_pc_pulse_r6: assert property (@(posedge clk) disable iff (por)
    (wdt_expire || ext_rst) |=> pc_reset);

  // R8: halt entry without a reset event
  p_halt_enter_r8: assert property (@(posedge clk) disable iff (por)
    (halt_enter && !wdt_expire && !ext_rst) |=> (!flag_to && flag_pd));

  // R10: a warm pulse lasts one cycle unless re-triggered
  p_warm_single_r10: assert property (@(posedge clk) disable iff (por)
    (warm_reset && !(wdt_expire && halted && !ext_rst)) |=> !warm_reset);

  // R9: status bits track the flags
  p_status_map_r9: assert property (@(posedge clk) disable iff (por)
    (status_o[TO_BIT] == flag_to) && (status_o[PD_BIT] == flag_pd));

endmodule

// File: tb/tb_rst_cause_status.sv
module tb_rst_cause_status;

  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 20240611;

  logic       clk = 1'b0;
  logic       por, wdt_expire, ext_rst, halted, halt_enter, flag_clear;
  logic       flag_to, flag_pd, pc_reset, cold_reset, warm_reset;
  logic [7:0] status_o;

  int errors = 0;
  int checks = 0;
  logic exp_to, exp_pd;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_status dut (
    .clk(clk), .por(por), .wdt_expire(wdt_expire), .ext_rst(ext_rst),
    .halted(halted), .halt_enter(halt_enter), .flag_clear(flag_clear),
    .flag_to(flag_to), .flag_pd(flag_pd), .status_o(status_o),
    .pc_reset(pc_reset), .cold_reset(cold_reset), .warm_reset(warm_reset)
  );

  // Expected {to, pd, pc, cold, warm} one cycle after the inputs
  function automatic logic [4:0] model(input logic w, input logic e,
                                       input logic h, input logic hn,
                                       input logic c, input logic t0,
                                       input logic p0);
    logic t, p, pc, cl, wm;
    t = t0; p = p0; pc = 0; cl = 0; wm = 0;
    if (e) begin
      pc = 1; cl = 1;
      if (h) begin t = 0; p = 1; end
    end else if (w) begin
      pc = 1; t = 1;
      if (h) begin p = 1; wm = 1; end
      else cl = 1;
    end else if (hn) begin
      t = 0; p = 1;
    end else if (c) begin
      t = 0; p = 0;
    end
    return {t, p, pc, cl, wm};
  endfunction

  function automatic string req_of(input logic w, input logic e,
                                   input logic h, input logic hn,
                                   input logic c);
    if (e && w) return "R7";
    if (e) return h ? "R4" : "R3";
    if (w) return h ? "R5" : "R2";
    if (hn || c) return "R8";
    return "R6";
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic check_all(input string req, input logic [4:0] e);
    chk(req, "flag_to", {7'd0, flag_to}, {7'd0, e[4]});
    chk(req, "flag_pd", {7'd0, flag_pd}, {7'd0, e[3]});
    chk(req, "pc_reset", {7'd0, pc_reset}, {7'd0, e[2]});
    chk(req, "cold_reset", {7'd0, cold_reset}, {7'd0, e[1]});
    chk(req, "warm_reset", {7'd0, warm_reset}, {7'd0, e[0]});
    chk("R9", "status_o", status_o, {2'b00, e[4], e[3], 4'b0000});
    if (warm_reset && cold_reset) chk("R10", "class overlap", 8'd1, 8'd0);
  endtask

  // Called at a falling edge; checks at the next falling edge
  task automatic step(input logic w, input logic e, input logic h,
                      input logic hn, input logic c);
    logic [4:0] ex;
    wdt_expire = w; ext_rst = e; halted = h; halt_enter = hn; flag_clear = c;
    ex = model(w, e, h, hn, c, exp_to, exp_pd);
    @(negedge clk);
    check_all(req_of(w, e, h, hn, c), ex);
    exp_to = ex[4];
    exp_pd = ex[3];
  endtask

  task automatic idle_inputs();
    wdt_expire = 0; ext_rst = 0; halted = 0; halt_enter = 0; flag_clear = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int r;
    por = 1'b1;
    idle_inputs();
    exp_to = 0; exp_pd = 0;
    repeat (2) @(negedge clk);
    check_all("R1", 5'b00110);
    por = 1'b0;
    // first cycle after release, no event
    step(0, 0, 0, 0, 0);

    // directed cases
    step(1, 0, 0, 0, 0);  // R2 watchdog run, pd stays 0
    step(0, 0, 0, 1, 0);  // R8 halt entry
    step(1, 0, 0, 0, 0);  // R2 watchdog run, pd stays 1
    step(0, 0, 0, 0, 0);  // R6 pulses drop
    step(0, 1, 0, 0, 0);  // R3 ext run keeps 1/1
    step(0, 0, 0, 0, 1);  // R8 clear
    step(0, 1, 1, 0, 0);  // R4 ext halted
    step(1, 0, 1, 0, 0);  // R5 warm
    step(1, 0, 1, 0, 0);  // R5 back-to-back warm
    step(0, 0, 0, 0, 0);  // R10 warm falls
    step(1, 1, 0, 0, 0);  // R7 ext beats wdt (run)
    step(1, 1, 1, 0, 0);  // R7 ext beats wdt (halted): cold, not warm
    step(0, 0, 0, 1, 1);  // R8 halt beats clear
    step(0, 1, 0, 1, 1);  // R7 reset beats halt and clear
    step(0, 0, 0, 0, 1);  // R8 clear

    // R1 and R7: power-on mid-cycle with other events present
    step(1, 0, 1, 0, 0);
    #(CLK_PERIOD/4);
    por = 1'b1;
    wdt_expire = 1; ext_rst = 1; halted = 1; halt_enter = 1;
    #(CLK_PERIOD/8);
    check_all("R1", 5'b00110);
    @(negedge clk);
    check_all("R7", 5'b00110);
    idle_inputs();
    por = 1'b0;
    exp_to = 0; exp_pd = 0;
    step(0, 0, 0, 0, 0);

    // seeded random mix
    r = $urandom(SEED);
    for (int i = 0; i < 2000; i++) begin
      logic w, e, h, hn, c;
      w  = ($urandom % 4) == 0;
      e  = ($urandom % 6) == 0;
      h  = ($urandom % 2) == 0;
      hn = ($urandom % 5) == 0;
      c  = ($urandom % 5) == 0;
      step(w, e, h, hn, c);
    end
    idle_inputs();
    finish_run();
  end

endmodule